// File: doc/BRIEF.md
# Incremental Delay-Line Tap Stepper

This block sets two incremental delay lines, a first line (A) and a second line (B), to requested tap positions. The lines cannot be loaded with a value. Each one only accepts a reset, a chip-enable, an increment/decrement bit and a shared step clock. The block therefore tracks each line's tap position itself and reaches a target by walking the line there one tap at a time.

A start pulse captures both targets. The block then runs a reset phase that returns both lines to their known starting taps. After that it steps line A until A's tracked tap equals its target, and only then steps line B. Every strobe is made of three phases: set-up, clock high and clock low. Each phase lasts a configurable number of system clocks, so that the delay line's setup and hold needs are met.

Top module: `dlt_stepper`

## Requirements
- R1: Out of reset, and while idle, busy_o, done_o, both resets, both enables, step_inc_o and step_clk_o are all low.
- R2: A start pulse while idle captures tgt_a_i and tgt_b_i (6-bit unsigned taps). Later changes on those inputs have no effect on the run in progress.
- R3: A start pulse while busy_o is high is ignored. The run keeps its original targets and its original length.
- R4: Each run begins with a reset phase. Both line resets are high together for three phases, and step_clk_o pulses high exactly once in the middle phase. No enable is asserted during the reset phase, and the resets are released before the first step.
- R5: After the reset phase, the tracked tap is 16 for line A and 32 for line B.
- R6: When a line's tracked tap is below its target, the block steps that line with step_inc_o high and the tap rises by one. Otherwise it steps with step_inc_o low and the tap falls by one. A line therefore receives exactly |target − start| steps and ends on its target.
- R7: All of line A's steps come before any of line B's steps.
- R8: During a step only the enable of the line being moved is high. The enable and step_inc_o are held unchanged across the set-up, clock-high and clock-low phases.
- R9: Each strobe phase lasts PHASE_CYC system clocks, so step_clk_o stays high for exactly PHASE_CYC cycles per pulse.
- R10: busy_o stays high for (N+1)·(3·PHASE_CYC+1) cycles, where N is the total number of steps. done_o then pulses for a single cycle while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| tgt_a_i | input | 6 | Target tap for line A |
| tgt_b_i | input | 6 | Target tap for line B |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| lna_rst_o | output | 1 | Line A reset |
| lnb_rst_o | output | 1 | Line B reset |
| lna_ce_o | output | 1 | Line A step enable |
| lnb_ce_o | output | 1 | Line B step enable |
| step_inc_o | output | 1 | Step direction: 1 increments, 0 decrements |
| step_clk_o | output | 1 | Step strobe shared by both lines |

## Verification
A model of the two delay lines in the bench follows the strobe pins and is compared with the targets at each done pulse. The target pairs are chosen to separate specific faults:
- Targets equal to the starting taps: a run with no steps, which exposes a wrong reset value or a spurious step.
- Targets at 0 and 63: the longest walks in each direction, which expose direction inversion and off-by-one endings.
- Mixed pairs (up on one line, down on the other): these show whether line B's walk waits for line A to finish.

Two further runs cover input handling. In one, the target inputs change right after start. In the other, a second start arrives mid-run. A design that failed to latch its targets, or that honoured a late start, would end on different taps or with a different run length.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_SU,
        ST_RST_HI,
        ST_RST_LO,
        ST_SEL,
        ST_STP_SU,
        ST_STP_HI,
        ST_STP_LO
    } dlt_state_e;

    typedef struct packed {
        dlt_state_e state;
        logic       sel_b;
        logic       inc;
        logic       done;
    } dlt_ctrl_t;

endpackage

// File: rtl/dlt_phase_timer.sv
module dlt_phase_timer #(
    parameter int PHASE_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic last_o
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == CW'(PHASE_CYC - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || last_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dlt_tap_track.sv
module dlt_tap_track #(
    parameter int TAP_W = 6,
    parameter int INIT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_load_i,
    input  logic [TAP_W-1:0] tgt_i,
    input  logic             init_i,
    input  logic             step_i,
    input  logic             inc_i,
    output logic             match_o,
    output logic             below_o
);
    typedef struct packed {
        logic [TAP_W-1:0] tgt;
        logic [TAP_W-1:0] cur;
    } trk_t;

    trk_t trk_d, trk_q;

    assign match_o = (trk_q.cur == trk_q.tgt);
    assign below_o = (trk_q.cur <  trk_q.tgt);

    always_comb begin
        trk_d = trk_q;
        if (tgt_load_i) begin
            trk_d.tgt = tgt_i;
        end
        if (init_i) begin
            trk_d.cur = TAP_W'(INIT);
        end else if (step_i) begin
            if (inc_i) begin
                trk_d.cur = trk_q.cur + TAP_W'(1);
            end else begin
                trk_d.cur = trk_q.cur - TAP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{tgt: TAP_W'(INIT), cur: TAP_W'(INIT)};
        end else begin
            trk_q <= trk_d;
        end
    end
endmodule

// File: rtl/dlt_stepper.sv
module dlt_stepper #(
    parameter int TAP_W     = 6,
    parameter int A_INIT    = 16,
    parameter int B_INIT    = 32,
    parameter int PHASE_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TAP_W-1:0] tgt_a_i,
    input  logic [TAP_W-1:0] tgt_b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             lna_rst_o,
    output logic             lnb_rst_o,
    output logic             lna_ce_o,
    output logic             lnb_ce_o,
    output logic             step_inc_o,
    output logic             step_clk_o
);
    import dlt_pkg::*;

    localparam int NLINE = 2;

    dlt_ctrl_t ctl_d, ctl_q;

    logic                        ph_last;
    logic                        ph_clear;
    logic                        tgt_load;
    logic                        trk_init;
    logic [NLINE-1:0]            step_en;
    logic [NLINE-1:0]            match;
    logic [NLINE-1:0]            below;
    logic [NLINE-1:0][TAP_W-1:0] tgt_in;

    assign tgt_in[0] = tgt_a_i;
    assign tgt_in[1] = tgt_b_i;

    dlt_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ph_clear),
        .last_o  (ph_last)
    );

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        dlt_tap_track #(
            .TAP_W (TAP_W),
            .INIT  ((g == 0) ? A_INIT : B_INIT)
        ) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .tgt_load_i (tgt_load),
            .tgt_i      (tgt_in[g]),
            .init_i     (trk_init),
            .step_i     (step_en[g]),
            .inc_i      (ctl_q.inc),
            .match_o    (match[g]),
            .below_o    (below[g])
        );
    end

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        tgt_load = 1'b0;
        trk_init = 1'b0;
        step_en  = '0;
        ph_clear = (ctl_q.state == ST_IDLE) || (ctl_q.state == ST_SEL);
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    tgt_load    = 1'b1;
                    ctl_d.state = ST_RST_SU;
                end
            end
            ST_RST_SU: if (ph_last) ctl_d.state = ST_RST_HI;
            ST_RST_HI: if (ph_last) ctl_d.state = ST_RST_LO;
            ST_RST_LO: begin
                if (ph_last) begin
                    trk_init    = 1'b1;
                    ctl_d.state = ST_SEL;
                end
            end
            ST_SEL: begin
                if (!match[0]) begin
                    ctl_d.sel_b = 1'b0;
                    ctl_d.inc   = below[0];
                    ctl_d.state = ST_STP_SU;
                end else if (!match[1]) begin
                    ctl_d.sel_b = 1'b1;
                    ctl_d.inc   = below[1];
                    ctl_d.state = ST_STP_SU;
                end else begin
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_STP_SU: if (ph_last) ctl_d.state = ST_STP_HI;
            ST_STP_HI: if (ph_last) ctl_d.state = ST_STP_LO;
            ST_STP_LO: begin
                if (ph_last) begin
                    step_en[ctl_q.sel_b] = 1'b1;
                    ctl_d.state          = ST_SEL;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, sel_b: 1'b0, inc: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic in_rst, in_step;
    assign in_rst  = (ctl_q.state == ST_RST_SU) || (ctl_q.state == ST_RST_HI) ||
                     (ctl_q.state == ST_RST_LO);
    assign in_step = (ctl_q.state == ST_STP_SU) || (ctl_q.state == ST_STP_HI) ||
                     (ctl_q.state == ST_STP_LO);

    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign done_o     = ctl_q.done;
    assign lna_rst_o  = in_rst;
    assign lnb_rst_o  = in_rst;
    assign lna_ce_o   = in_step && !ctl_q.sel_b;
    assign lnb_ce_o   = in_step &&  ctl_q.sel_b;
    assign step_inc_o = in_step && ctl_q.inc;
    assign step_clk_o = (ctl_q.state == ST_RST_HI) || (ctl_q.state == ST_STP_HI);
endmodule

// File: rtl/dlt_stepper_chk.sv
module dlt_stepper_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic lna_rst_o,
    input logic lnb_rst_o,
    input logic lna_ce_o,
    input logic lnb_ce_o,
    input logic step_inc_o,
    input logic step_clk_o
);
    logic b_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_seen_q <= 1'b0;
        end else if (!busy_o) begin
            b_seen_q <= 1'b0;
        end else if (lnb_ce_o) begin
            b_seen_q <= 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(lna_rst_o || lnb_rst_o || lna_ce_o || lnb_ce_o || step_clk_o || step_inc_o));

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_rst_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lna_rst_o == lnb_rst_o);

    p_rst_no_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lna_rst_o |-> !(lna_ce_o || lnb_ce_o));

    p_a_before_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lna_ce_o |-> !b_seen_q);

    p_one_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lna_ce_o && lnb_ce_o));

    p_ce_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_clk_o) |-> ($stable(lna_ce_o) && $stable(lnb_ce_o) &&
                               $stable(step_inc_o) && $stable(lna_rst_o)));

    p_ce_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_clk_o) |-> ($stable(lna_ce_o) && $stable(lnb_ce_o) &&
                               $stable(step_inc_o) && $stable(lna_rst_o)));

    p_clk_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_clk_o |-> (lna_rst_o || lna_ce_o || lnb_ce_o));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind dlt_stepper dlt_stepper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .lna_rst_o  (lna_rst_o),
    .lnb_rst_o  (lnb_rst_o),
    .lna_ce_o   (lna_ce_o),
    .lnb_ce_o   (lnb_ce_o),
    .step_inc_o (step_inc_o),
    .step_clk_o (step_clk_o)
);

// File: tb/dlt_stepper_bench.sv
module dlt_stepper_bench;
    localparam int PH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [5:0] tgt_a_i = '0;
    logic [5:0] tgt_b_i = '0;
    logic busy_o, done_o, lna_rst_o, lnb_rst_o, lna_ce_o, lnb_ce_o, step_inc_o, step_clk_o;

    always #2.5 clk = ~clk;

    dlt_stepper #(.TAP_W(6), .A_INIT(16), .B_INIT(32), .PHASE_CYC(PH)) u_dlt_stepper (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_a_i(tgt_a_i), .tgt_b_i(tgt_b_i),
        .busy_o(busy_o), .done_o(done_o), .lna_rst_o(lna_rst_o), .lnb_rst_o(lnb_rst_o),
        .lna_ce_o(lna_ce_o), .lnb_ce_o(lnb_ce_o), .step_inc_o(step_inc_o),
        .step_clk_o(step_clk_o)
    );

    typedef struct { int a; int b; int cyc; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int fails  = 0;
    int runs_done = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: delay-line model and per-run scoreboard
    int  mdl_a = 0, mdl_b = 0;
    int  a_steps = 0, b_steps = 0, rst_pulses = 0, busy_cyc = 0, hi_w = 0;
    bit  b_started = 0, order_bad = 0, width_bad = 0, rst_bad = 0, prev_sclk = 0, prev_busy = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !prev_busy) begin
                a_steps = 0; b_steps = 0; rst_pulses = 0; busy_cyc = 0;
                b_started = 0; order_bad = 0; width_bad = 0; rst_bad = 0;
            end
            if (busy_o) busy_cyc++;
            if (step_clk_o) hi_w++;
            if (step_clk_o && !prev_sclk) begin
                if (lna_rst_o || lnb_rst_o) begin
                    rst_pulses++;
                    if (!(lna_rst_o && lnb_rst_o) || lna_ce_o || lnb_ce_o || a_steps + b_steps != 0)
                        rst_bad = 1;
                    mdl_a = 16; mdl_b = 32;
                end else begin
                    if (lna_ce_o) begin
                        a_steps++;
                        if (b_started) order_bad = 1;
                        mdl_a = step_inc_o ? mdl_a + 1 : mdl_a - 1;
                    end
                    if (lnb_ce_o) begin
                        b_steps++;
                        b_started = 1;
                        mdl_b = step_inc_o ? mdl_b + 1 : mdl_b - 1;
                    end
                end
            end
            if (!step_clk_o && prev_sclk) begin
                if (hi_w != PH) width_bad = 1;
                hi_w = 0;
            end
            if (done_o) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mdl_a == e.a, "R6 line A final tap", mdl_a, e.a);
                    chk(mdl_b == e.b, "R6 line B final tap", mdl_b, e.b);
                    chk(a_steps == ((e.a > 16) ? e.a - 16 : 16 - e.a), "R5 line A step count", a_steps, e.a);
                    chk(b_steps == ((e.b > 32) ? e.b - 32 : 32 - e.b), "R5 line B step count", b_steps, e.b);
                    chk(!order_bad, "R7 A before B", order_bad, 0);
                    chk(rst_pulses == 1 && !rst_bad, "R4 reset phase", rst_pulses, 1);
                    chk(!width_bad, "R9 strobe high width", width_bad, 0);
                    chk(busy_cyc == e.cyc, "R10 busy length", busy_cyc, e.cyc);
                    chk(!busy_o, "R10 done with busy low", busy_o, 0);
                end
                runs_done++;
            end
            prev_sclk = step_clk_o;
            prev_busy = busy_o;
        end
    end

    // driver
    task automatic run_case(input int a, input int b, input bit alter_tgt, input bit late_start);
        exp_t e;
        int n;
        int target_runs;
        n = ((a > 16) ? a - 16 : 16 - a) + ((b > 32) ? b - 32 : 32 - b);
        e.a = a; e.b = b; e.cyc = (n + 1) * (3 * PH + 1);
        exp_q.push_back(e);
        target_runs = runs_done + 1;
        @(negedge clk);
        tgt_a_i = 6'(a); tgt_b_i = 6'(b); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (alter_tgt) begin   // R2: inputs move after capture
            tgt_a_i = 6'(63 - a); tgt_b_i = 6'(63 - b);
        end
        if (late_start) begin  // R3: second start while busy
            repeat (12) @(negedge clk);
            tgt_a_i = 6'd1; tgt_b_i = 6'd2; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (runs_done < target_runs) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o, "R1 reset busy/done", {busy_o, done_o}, 0);
        chk({lna_rst_o, lnb_rst_o, lna_ce_o, lnb_ce_o, step_inc_o, step_clk_o} == 6'b0,
            "R1 reset strobes", {lna_rst_o, lnb_rst_o, lna_ce_o, lnb_ce_o, step_inc_o, step_clk_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !step_clk_o, "R1 idle after release", busy_o, 0);
        run_case(16, 32, 0, 0);   // R5: no steps
        run_case(20, 30, 0, 0);   // R6 mixed directions
        run_case(0, 63, 0, 0);    // R6 extremes
        run_case(63, 0, 0, 0);
        run_case(10, 40, 1, 0);   // R2
        run_case(5, 50, 0, 1);    // R3
        chk(exp_q.size() == 0, "R3 no extra run", exp_q.size(), 0);
        chk(!busy_o && !done_o, "R1 idle at end", busy_o, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule